// File: doc/BRIEF.md
# Ultra DMA Burst CRC Checker

This block sits on the device side of an Ultra DMA data path and guards the integrity of each burst. While a burst runs, every 16-bit data word that crosses the bus is folded into a running CRC. The CRC uses the generator x^16 + x^12 + x^5 + 1 and is loaded with a fixed start value each time a burst opens. When the burst closes, the host presents its own CRC word. The block compares that word with its local result and raises an error when the two differ.

A command may span several bursts. The error indication belongs to the command, not to a single burst. The first mismatch sets a sticky flag and records which burst of the command produced it. Later mismatches in the same command leave both untouched. Everything clears only when the next command begins.

A mode input sets how the device reacts to an error. In one setting the transfer runs to completion and the error is reported at the end. In the other setting the block also raises an abort request, so that the command can be stopped early.

Top module: `burst_crc_guard`

## Requirements
- R1: After reset, `crc_err` and `abort_req` are 0 and `err_burst` is 0.
- R2: Each `word_valid` cycle folds the whole 16-bit `word_data` into the CRC in one clock. The CRC is CRC-16 with polynomial 0x1021, processed MSB first, with no reflection and no final XOR. When `host_crc` matches the local CRC, no error is flagged.
- R3: `burst_start` reloads the CRC with 0x4ABA, so a new burst's CRC does not depend on words from earlier bursts.
- R4: A `host_crc_valid` cycle whose `host_crc` differs from the local CRC sets `crc_err` on the following cycle. The comparison uses the CRC value held before that cycle.
- R5: `err_burst` captures the 1-based number of the burst, counted from the last `cmd_start`, in which the first mismatch of the command occurred.
- R6: Once `crc_err` is set, further mismatches in the same command change neither `crc_err` nor `err_burst`.
- R7: `crc_err` and `err_burst` hold through `cmd_end` and idle cycles. They clear on the cycle after `cmd_start`, which also resets the burst count to 0.
- R8: With `abort_on_err`=1, a mismatch raises `abort_req` on the following cycle. `abort_req` then stays high until the cycle after `cmd_end` or `cmd_start`.
- R9: With `abort_on_err`=0, `abort_req` stays 0 even when a mismatch is flagged, and `crc_err` is still reported.
- R10: When `burst_start` and `word_valid` occur in the same cycle, the word is folded into the seed 0x4ABA.
- R11: When `cmd_start` coincides with a mismatching `host_crc_valid`, the clear wins and `crc_err` stays 0.
- R12: The burst number saturates at 2^CNT_W−1 (15 by default). A first error in a later burst records that saturated value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Pulse: a new command begins |
| cmd_end | input | 1 | Pulse: the current command has ended |
| burst_start | input | 1 | Pulse: a burst begins; reseeds the CRC |
| word_valid | input | 1 | A data word is transferred this cycle |
| word_data | input | 16 | Data word being transferred |
| host_crc_valid | input | 1 | The host CRC word is presented this cycle |
| host_crc | input | 16 | CRC value sent by the host |
| abort_on_err | input | 1 | 1: request abort on error; 0: complete, then report |
| crc_err | output | 1 | Sticky CRC error flag for the current command |
| err_burst | output | CNT_W | Burst number of the first error (0 = none) |
| abort_req | output | 1 | Abort request in abort-on-error mode |

## Verification
Bursts of different lengths and contents are closed with the correct CRC. These distinguish a correct polynomial, bit order and reseed from an engine that carries state across bursts or folds bits in the wrong order. Corrupted CRC words are placed in the third burst and then again in a later burst. These separate first-error capture from last-error overwrite, and show whether the flag is sticky through command end. Both mode settings are run, to tell reporting apart from the abort request. Coincident `cmd_start`/mismatch and `burst_start`/word cycles exercise the priority rules. A run of more than fifteen bursts covers counter saturation.

// File: rtl/burst_crc_pkg.sv
package burst_crc_pkg;
  localparam int CRC_W = 16;
  typedef logic [CRC_W-1:0] crc_t;

  // Fold one full word into the CRC, MSB first, one bit per step.
  function automatic crc_t crc_fold(input crc_t cur, input crc_t word, input crc_t poly);
    crc_t c;
    logic fb;
    c = cur;
    for (int i = CRC_W - 1; i >= 0; i--) begin
      fb = c[CRC_W-1] ^ word[i];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ poly;
    end
    return c;
  endfunction

  // Saturating increment for the burst counter.
  function automatic int unsigned sat_inc(input int unsigned v, input int unsigned lim);
    return (v >= lim) ? lim : v + 1;
  endfunction
endpackage

// File: rtl/crc_lane.sv
module crc_lane
  import burst_crc_pkg::*;
#(
  parameter crc_t SEED = 16'h4ABA,
  parameter crc_t POLY = 16'h1021
) (
  input  logic clk,
  input  logic rst_n,
  input  logic reseed,
  input  logic fold,
  input  crc_t word,
  output crc_t crc_q
);
  crc_t base;
  assign base = reseed ? SEED : crc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc_q <= SEED;
    end else if (fold) begin
      crc_q <= crc_fold(base, word, POLY);
    end else if (reseed) begin
      crc_q <= SEED;
    end
  end
endmodule

// File: rtl/burst_tally.sv
module burst_tally
  import burst_crc_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             bump,
  output logic [CNT_W-1:0] count
);
  localparam int unsigned LIMIT = (1 << CNT_W) - 1;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      count <= '0;
    end else if (bump) begin
      count <= CNT_W'(sat_inc(int'(count), LIMIT));
    end
  end
endmodule

// File: rtl/err_capture.sv
module err_capture #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_start,
  input  logic             cmd_end,
  input  logic             miss,
  input  logic [CNT_W-1:0] cur_burst,
  input  logic             abort_mode,
  output logic             err_q,
  output logic [CNT_W-1:0] idx_q,
  output logic             abort_q
);
  logic first_hit;
  assign first_hit = miss && !err_q;

  always_ff @(posedge clk) begin
    if (!rst_n || cmd_start) begin
      err_q   <= 1'b0;
      idx_q   <= '0;
      abort_q <= 1'b0;
    end else begin
      if (first_hit) begin
        err_q <= 1'b1;
        idx_q <= cur_burst;
      end
      if (miss && abort_mode) begin
        abort_q <= 1'b1;
      end else if (cmd_end) begin
        abort_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/burst_crc_guard.sv
module burst_crc_guard
  import burst_crc_pkg::*;
#(
  parameter int   CNT_W = 4,
  parameter crc_t SEED  = 16'h4ABA,
  parameter crc_t POLY  = 16'h1021
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_start,
  input  logic             cmd_end,
  input  logic             burst_start,
  input  logic             word_valid,
  input  logic [15:0]      word_data,
  input  logic             host_crc_valid,
  input  logic [15:0]      host_crc,
  input  logic             abort_on_err,
  output logic             crc_err,
  output logic [CNT_W-1:0] err_burst,
  output logic             abort_req
);
  crc_t             crc_state;
  logic [CNT_W-1:0] burst_no;
  logic             crc_miss;

  crc_lane #(.SEED(SEED), .POLY(POLY)) u_lane (
    .clk   (clk),
    .rst_n (rst_n),
    .reseed(burst_start),
    .fold  (word_valid),
    .word  (word_data),
    .crc_q (crc_state)
  );

  burst_tally #(.CNT_W(CNT_W)) u_tally (
    .clk  (clk),
    .rst_n(rst_n),
    .clear(cmd_start),
    .bump (burst_start),
    .count(burst_no)
  );

  assign crc_miss = host_crc_valid && (host_crc != crc_state);

  err_capture #(.CNT_W(CNT_W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_start (cmd_start),
    .cmd_end   (cmd_end),
    .miss      (crc_miss),
    .cur_burst (burst_no),
    .abort_mode(abort_on_err),
    .err_q     (crc_err),
    .idx_q     (err_burst),
    .abort_q   (abort_req)
  );
endmodule

// File: rtl/burst_crc_guard_chk.sv
module burst_crc_guard_chk #(
  parameter int          CNT_W = 4,
  parameter logic [15:0] SEED  = 16'h4ABA
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_start,
  input logic             cmd_end,
  input logic             burst_start,
  input logic             word_valid,
  input logic             abort_on_err,
  input logic             crc_miss,
  input logic [15:0]      crc_state,
  input logic             crc_err,
  input logic [CNT_W-1:0] err_burst,
  input logic             abort_req
);
  // R3
  reseed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_start && !word_valid |=> crc_state == SEED);

  // R4
  miss_sets_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crc_miss && !cmd_start |=> crc_err);

  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crc_err && !cmd_start |=> crc_err && $stable(err_burst));

  // R7
  cmd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |=> !crc_err && !abort_req && err_burst == '0);

  // R9
  abort_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(abort_req) |-> $past(abort_on_err) && $past(crc_miss));

  // R8
  abort_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(abort_req) |-> $past(cmd_end) || $past(cmd_start));
endmodule

bind burst_crc_guard burst_crc_guard_chk #(.CNT_W(CNT_W), .SEED(SEED)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_start   (cmd_start),
  .cmd_end     (cmd_end),
  .burst_start (burst_start),
  .word_valid  (word_valid),
  .abort_on_err(abort_on_err),
  .crc_miss    (crc_miss),
  .crc_state   (crc_state),
  .crc_err     (crc_err),
  .err_burst   (err_burst),
  .abort_req   (abort_req)
);

// File: tb/burst_crc_guard_bench.sv
`timescale 1ns/1ps
module burst_crc_guard_bench;
  localparam int CNT_W = 4;
  localparam int SAT   = (1 << CNT_W) - 1;
  localparam logic [15:0] SEED_V = 16'h4ABA;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_start = 0, cmd_end = 0, burst_start = 0, word_valid = 0;
  logic host_crc_valid = 0, abort_on_err = 0;
  logic [15:0] word_data = '0, host_crc = '0;
  logic crc_err, abort_req;
  logic [CNT_W-1:0] err_burst;

  always #2.5 clk = ~clk;

  burst_crc_guard u_burst_crc_guard (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_end(cmd_end),
    .burst_start(burst_start), .word_valid(word_valid), .word_data(word_data),
    .host_crc_valid(host_crc_valid), .host_crc(host_crc),
    .abort_on_err(abort_on_err), .crc_err(crc_err), .err_burst(err_burst),
    .abort_req(abort_req)
  );

  typedef struct {
    int    due;
    logic  err;
    int    idx;
    logic  abt;
    string req;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int checks = 0;
  int fails = 0;

  // reference model state
  logic [15:0] m_crc = SEED_V;
  int          m_cnt = 0;
  logic        m_err = 0;
  int          m_idx = 0;
  logic        m_abt = 0;

  // Data XORed in whole, then shifted sixteen times.
  function automatic logic [15:0] ref_fold(input logic [15:0] c, input logic [15:0] w);
    logic [15:0] r;
    r = c ^ w;
    repeat (16) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
    return r;
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (crc_err !== e.err || int'(err_burst) != e.idx || abort_req !== e.abt) begin
        fails++;
        $display("FAIL %s: got err=%0b idx=%0d abort=%0b, expected err=%0b idx=%0d abort=%0b",
                 e.req, crc_err, err_burst, abort_req, e.err, e.idx, e.abt);
      end
    end
  end

  task automatic drive(input logic cs, input logic ce, input logic bs, input logic wv,
                       input logic [15:0] wd, input logic hv, input logic [15:0] hc,
                       input string req);
    logic miss;
    exp_t e;
    cmd_start = cs; cmd_end = ce; burst_start = bs; word_valid = wv;
    word_data = wd; host_crc_valid = hv; host_crc = hc;
    miss = hv && (hc != m_crc);
    if (wv) m_crc = ref_fold(bs ? SEED_V : m_crc, wd);
    else if (bs) m_crc = SEED_V;
    if (cs) begin
      m_err = 0; m_idx = 0; m_abt = 0;
    end else begin
      if (miss && !m_err) begin m_err = 1; m_idx = m_cnt; end
      if (miss && abort_on_err) m_abt = 1;
      else if (ce) m_abt = 0;
    end
    if (cs) m_cnt = 0;
    else if (bs) m_cnt = (m_cnt >= SAT) ? SAT : m_cnt + 1;
    e.due = cyc + 1; e.err = m_err; e.idx = m_idx; e.abt = m_abt; e.req = req;
    q.push_back(e);
    @(negedge clk);
    cmd_start = 0; cmd_end = 0; burst_start = 0; word_valid = 0; host_crc_valid = 0;
  endtask

  task automatic idle(input string req);
    drive(0, 0, 0, 0, 16'h0, 0, 16'h0, req);
  endtask

  task automatic burst(input int n, input logic [15:0] base, input logic good, input string req);
    drive(0, 0, 1, 0, 16'h0, 0, 16'h0, req);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 1, base + 16'(i * 16'h1357), 0, 16'h0, req);
    drive(0, 0, 0, 0, 16'h0, 1, good ? m_crc : (m_crc ^ 16'h0100), req);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    checks++;
    if (crc_err !== 0 || err_burst !== '0 || abort_req !== 0) begin
      fails++;
      $display("FAIL R1: got err=%0b idx=%0d abort=%0b, expected 0 0 0", crc_err, err_burst, abort_req);
    end

    // complete-then-report mode
    abort_on_err = 0;
    drive(1, 0, 0, 0, 16'h0, 0, 16'h0, "R7");
    burst(3, 16'hA5C3, 1, "R2");
    burst(2, 16'h0F0F, 1, "R3");
    burst(4, 16'h1234, 0, "R4 R5 R9");
    burst(1, 16'hFFFF, 0, "R6");
    drive(0, 1, 0, 0, 16'h0, 0, 16'h0, "R7");
    repeat (3) idle("R7");
    drive(1, 0, 0, 0, 16'h0, 0, 16'h0, "R7");
    idle("R7");

    // abort-on-error mode
    abort_on_err = 1;
    drive(1, 0, 0, 0, 16'h0, 0, 16'h0, "R8");
    burst(5, 16'h8001, 1, "R2");
    burst(2, 16'h4444, 0, "R8");
    repeat (2) idle("R8");
    drive(0, 1, 0, 0, 16'h0, 0, 16'h0, "R8");
    idle("R8");

    // clear wins over a same-cycle mismatch
    drive(1, 0, 0, 0, 16'h0, 1, m_crc ^ 16'h0001, "R11");
    idle("R11");

    // word folded into the seed on the burst_start cycle
    abort_on_err = 0;
    drive(1, 0, 0, 0, 16'h0, 0, 16'h0, "R10");
    drive(0, 0, 1, 1, 16'hBEEF, 0, 16'h0, "R10");
    drive(0, 0, 0, 1, 16'h0001, 0, 16'h0, "R10");
    drive(0, 0, 0, 0, 16'h0, 1, ref_fold(ref_fold(SEED_V, 16'hBEEF), 16'h0001), "R10");
    idle("R10");

    // counter saturation
    drive(1, 0, 0, 0, 16'h0, 0, 16'h0, "R12");
    for (int b = 0; b < SAT + 2; b++) burst(1, 16'(b * 16'h0777), 1, "R12");
    burst(2, 16'h2222, 0, "R12");
    idle("R12");

    repeat (3) @(negedge clk);
    report();
  end
endmodule